// File: doc/BRIEF.md
# Serial Bitstream Reconfiguration Controller

This block sequences the dynamic reconfiguration of a processing-element array. Three serial configuration lines run in parallel. The first carries the 64-bit immediate constants of every element. The second carries the operand-selector bits of every element. The third carries the settings of the routing switches. Each line shifts into a shadow chain sized by parameters. When the longest stream has been fully received, the controller moves all three chains into the active configuration registers in a single clock edge. It then waits for a start-execution request and holds the array in a run state until execution ends.

For each line there is a take strobe. The strobe tells the bit source that the bit presented in the current cycle will be consumed at the next clock edge. Shorter streams finish early and their strobes drop. The controller always works through four states in a fixed order: idle, loading, waiting and running. Requests that arrive in a state that does not accept them are dropped.

Top module: `bitstream_reconfig_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the state output is idle (code 0), busy, done and run are low, and all three committed configuration outputs are zero.
- R2: The state codes are idle=0, loading=1, waiting=2, running=3. In idle, start_cfg high at a clock edge moves the controller to loading, and busy stays high for the whole loading state.
- R3: During loading, the three lines shift one bit per clock at the same time. Each line's take strobe is high for exactly its first LEN cycles of loading. LEN is NUM_PE*IMM_W for the immediate line, NUM_PE*3*ceil(log2(2*(2*MCL+1))) for the selector line, and NUM_PE*RTE_W for the routing line.
- R4: On each line, the bit taken in loading cycle k (counted from 0) appears at bit LEN-1-k of that line's committed output. The first bit taken ends up in the MSB.
- R5: Loading lasts exactly as many cycles as the longest stream. The controller then enters waiting with done high and busy low.
- R6: The committed outputs do not change during loading. All three update together at the clock edge that leaves loading, so no partial configuration is ever visible.
- R7: A bit presented on a line while that line's take strobe is low has no effect on the committed configuration.
- R8: In waiting, start_exec moves the controller to running with run high. In running, exec_end returns it to idle.
- R9: start_exec in idle, loading or running is ignored. exec_end outside running is ignored.
- R10: start_cfg in loading, waiting or running is ignored and leaves the committed outputs unchanged.
- R11: The committed configuration holds through waiting, running and idle until the commit of the next reconfiguration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cfg | input | 1 | Request to begin reconfiguration |
| start_exec | input | 1 | Request to begin execution |
| exec_end | input | 1 | Execution has finished |
| imm_sin | input | 1 | Serial bit for the immediate-constant stream |
| sel_sin | input | 1 | Serial bit for the operand-selector stream |
| rte_sin | input | 1 | Serial bit for the routing-switch stream |
| imm_take | output | 1 | The immediate bit is consumed at the next edge |
| sel_take | output | 1 | The selector bit is consumed at the next edge |
| rte_take | output | 1 | The routing bit is consumed at the next edge |
| imm_cfg | output | NUM_PE*IMM_W | Committed immediate constants |
| sel_cfg | output | NUM_PE*SEL_PE_W | Committed selector bits |
| rte_cfg | output | NUM_PE*RTE_W | Committed routing bits |
| state | output | 2 | Current state code |
| busy | output | 1 | Loading in progress |
| done | output | 1 | Configuration committed, waiting for execution |
| run | output | 1 | Execution state |

## Verification
The bench loads the three streams with random, all-ones and alternating patterns. It checks every committed bit against a model of the shift order. A reversed shift direction, or one position off, breaks the MSB check. The bench also checks that the committed outputs still hold the old configuration in the last loading cycle. A design that updated the outputs as bits arrived would fail there. It also feeds junk bits on the shorter lines after their strobes drop, so a design that kept shifting them would commit shifted-out data. Requests that the current state does not accept are fired in idle, in the middle of loading, in waiting and in running. A design that took them would leave loading too early, start execution without a configuration, or reload during execution.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_HOLD = 2'd2,
    ST_RUN  = 2'd3
  } rcfg_state_e;

  // selector bits per element: three operand inputs, each picking one of 2*(2*MCL+1) sources
  function automatic int sel_bits_per_pe(input int mcl);
    return 3 * $clog2(2 * (2 * mcl + 1));
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rcfg_fsm.sv
module rcfg_fsm
  import rcfg_pkg::*;
#(
  parameter int MAX_LEN = 256,
  parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_cfg,
  input  logic             start_exec,
  input  logic             exec_end,
  output rcfg_state_e      state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o,
  output logic             commit_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             run_o
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAX_LEN - 1);

  rcfg_state_e      st_q, st_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q, run_q;
  logic             last;

  assign last = (st_q == ST_LOAD) && (cnt_q == LAST_CNT);

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE: if (start_cfg)  st_nxt = ST_LOAD;
      ST_LOAD: if (last)       st_nxt = ST_HOLD;
      ST_HOLD: if (start_exec) st_nxt = ST_RUN;
      ST_RUN:  if (exec_end)   st_nxt = ST_IDLE;
      default:                 st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      cnt_q  <= (st_q == ST_LOAD && !last) ? cnt_q + 1'b1 : '0;
      busy_q <= (st_nxt == ST_LOAD);
      done_q <= (st_nxt == ST_HOLD);
      run_q  <= (st_nxt == ST_RUN);
    end
  end

  assign state_o  = st_q;
  assign cnt_o    = cnt_q;
  assign load_o   = (st_q == ST_LOAD);
  assign commit_o = last;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign run_o    = run_q;

  AST_LOAD_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOAD && $past(st_q) != ST_LOAD) |-> $past(st_q) == ST_IDLE); // R2
  AST_LOAD_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOAD) |-> (cnt_q <= LAST_CNT)); // R5
  AST_HOLD_AFTER_FULL: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD && $past(st_q) != ST_HOLD) |-> $past(cnt_q) == LAST_CNT); // R5
  AST_NO_RUN_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |=> (st_q != ST_RUN)); // R9
  AST_NO_RELOAD_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN) |=> (st_q != ST_LOAD)); // R10

endmodule

// File: rtl/rcfg_chain.sv
module rcfg_chain #(
  parameter int LEN   = 64,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             commit_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             sin,
  output logic             take_o,
  output logic [LEN-1:0]   act_o
);

  localparam logic [CNT_W-1:0] LEN_C = CNT_W'(LEN);

  logic [LEN-1:0] shd_q, shd_nxt, act_q;

  assign take_o = load_i && (cnt_i < LEN_C);

  generate
    if (LEN == 1) begin : g_one
      assign shd_nxt = take_o ? sin : shd_q;
    end else begin : g_many
      assign shd_nxt = take_o ? {shd_q[LEN-2:0], sin} : shd_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      shd_q <= shd_nxt;
      if (commit_i) act_q <= shd_nxt;
    end
  end

  assign act_o = act_q;

  AST_ACT_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(act_q)); // R6
  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !take_o |=> $stable(shd_q)); // R7

endmodule

// File: rtl/bitstream_reconfig_ctrl.sv
module bitstream_reconfig_ctrl
  import rcfg_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int IMM_W  = 64,
  parameter int MCL    = 2,
  parameter int RTE_W  = 8,
  localparam int SEL_PE_W = sel_bits_per_pe(MCL),
  localparam int IMM_LEN  = NUM_PE * IMM_W,
  localparam int SEL_LEN  = NUM_PE * SEL_PE_W,
  localparam int RTE_LEN  = NUM_PE * RTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_cfg,
  input  logic               start_exec,
  input  logic               exec_end,
  input  logic               imm_sin,
  input  logic               sel_sin,
  input  logic               rte_sin,
  output logic               imm_take,
  output logic               sel_take,
  output logic               rte_take,
  output logic [IMM_LEN-1:0] imm_cfg,
  output logic [SEL_LEN-1:0] sel_cfg,
  output logic [RTE_LEN-1:0] rte_cfg,
  output logic [1:0]         state,
  output logic               busy,
  output logic               done,
  output logic               run
);

  localparam int MAX_LEN = max3(IMM_LEN, SEL_LEN, RTE_LEN);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  rcfg_state_e      st;
  logic [CNT_W-1:0] cnt;
  logic             load, commit;

  rcfg_fsm #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_fsm (
    .clk, .rst, .start_cfg, .start_exec, .exec_end,
    .state_o(st), .cnt_o(cnt), .load_o(load), .commit_o(commit),
    .busy_o(busy), .done_o(done), .run_o(run)
  );

  assign state = st;

  rcfg_chain #(.LEN(IMM_LEN), .CNT_W(CNT_W)) u_imm (
    .clk, .rst, .load_i(load), .commit_i(commit), .cnt_i(cnt),
    .sin(imm_sin), .take_o(imm_take), .act_o(imm_cfg)
  );

  rcfg_chain #(.LEN(SEL_LEN), .CNT_W(CNT_W)) u_sel (
    .clk, .rst, .load_i(load), .commit_i(commit), .cnt_i(cnt),
    .sin(sel_sin), .take_o(sel_take), .act_o(sel_cfg)
  );

  rcfg_chain #(.LEN(RTE_LEN), .CNT_W(CNT_W)) u_rte (
    .clk, .rst, .load_i(load), .commit_i(commit), .cnt_i(cnt),
    .sin(rte_sin), .take_o(rte_take), .act_o(rte_cfg)
  );

  AST_RUN_NEEDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && $past(st) != ST_RUN) |-> $past(st) == ST_HOLD); // R8
  AST_CFG_HELD_OUTSIDE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (st != ST_LOAD) |=> $stable(imm_cfg) && $stable(sel_cfg) && $stable(rte_cfg)); // R11

endmodule

// File: tb/test_bitstream_reconfig_ctrl.sv
module test_bitstream_reconfig_ctrl;

  localparam int NUM_PE  = 4;
  localparam int IMM_W   = 64;
  localparam int MCL     = 2;
  localparam int RTE_W   = 8;
  localparam int SEL_PE  = 3 * $clog2(2 * (2 * MCL + 1));
  localparam int IMM_LEN = NUM_PE * IMM_W;
  localparam int SEL_LEN = NUM_PE * SEL_PE;
  localparam int RTE_LEN = NUM_PE * RTE_W;
  localparam int MAX_LEN = IMM_LEN;   // largest of the three with these parameters
  localparam int W       = MAX_LEN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_cfg = 1'b0, start_exec = 1'b0, exec_end = 1'b0;
  logic imm_sin = 1'b0, sel_sin = 1'b0, rte_sin = 1'b0;
  logic imm_take, sel_take, rte_take, busy, done, run;
  logic [IMM_LEN-1:0] imm_cfg;
  logic [SEL_LEN-1:0] sel_cfg;
  logic [RTE_LEN-1:0] rte_cfg;
  logic [1:0] state;

  int checks = 0;
  int errors = 0;

  logic [IMM_LEN-1:0] exp_imm;
  logic [SEL_LEN-1:0] exp_sel;
  logic [RTE_LEN-1:0] exp_rte;

  always #10 clk = ~clk;

  bitstream_reconfig_ctrl #(.NUM_PE(NUM_PE), .IMM_W(IMM_W), .MCL(MCL), .RTE_W(RTE_W)) i_bitstream_reconfig_ctrl (
    .clk, .rst, .start_cfg, .start_exec, .exec_end, .imm_sin, .sel_sin, .rte_sin,
    .imm_take, .sel_take, .rte_take, .imm_cfg, .sel_cfg, .rte_cfg,
    .state, .busy, .done, .run
  );

  function automatic logic exp_take(input int k, input int len);
    return k < len;
  endfunction

  function automatic logic pat_bit(input int mode, input int k);
    case (mode)
      1: return 1'b1;
      2: return k[0];
      default: return 1'($urandom);
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_state(input string req, input logic [1:0] s, input logic b, input logic d, input logic r);
    chk({req, " state"}, W'(state), W'(s));
    chk({req, " busy"}, W'(busy), W'(b));
    chk({req, " done"}, W'(done), W'(d));
    chk({req, " run"}, W'(run), W'(r));
  endtask

  task automatic chk_cfg(input string req);
    chk({req, " imm_cfg"}, W'(imm_cfg), W'(exp_imm));
    chk({req, " sel_cfg"}, W'(sel_cfg), W'(exp_sel));
    chk({req, " rte_cfg"}, W'(rte_cfg), W'(exp_rte));
  endtask

  // poke: 0 none, 1 start_exec mid-load, 2 exec_end mid-load, 3 start_cfg mid-load
  task automatic do_load(input int mode, input int poke, input int poke_at);
    logic [IMM_LEN-1:0] n_imm;
    logic [SEL_LEN-1:0] n_sel;
    logic [RTE_LEN-1:0] n_rte;
    n_imm = exp_imm; n_sel = exp_sel; n_rte = exp_rte;
    start_cfg = 1'b1;
    tick();
    start_cfg = 1'b0;
    for (int k = 0; k < MAX_LEN; k++) begin
      imm_sin = pat_bit(mode, k);
      sel_sin = pat_bit(mode, k + 1);
      rte_sin = pat_bit(mode, k + 2);
      if (exp_take(k, IMM_LEN)) n_imm = {n_imm[IMM_LEN-2:0], imm_sin};
      if (exp_take(k, SEL_LEN)) n_sel = {n_sel[SEL_LEN-2:0], sel_sin};
      if (exp_take(k, RTE_LEN)) n_rte = {n_rte[RTE_LEN-2:0], rte_sin};
      start_exec = (poke == 1 && k == poke_at);
      exec_end   = (poke == 2 && k == poke_at);
      start_cfg  = (poke == 3 && k == poke_at);
      #1;
      if (k == 0 || k == MAX_LEN - 1 || k == poke_at || k == SEL_LEN || k == RTE_LEN) begin
        chk_state("R2 R9 R10 loading", 2'd1, 1'b1, 1'b0, 1'b0);
        chk("R3 imm_take", W'(imm_take), W'(exp_take(k, IMM_LEN)));
        chk("R3 sel_take", W'(sel_take), W'(exp_take(k, SEL_LEN)));
        chk("R3 rte_take", W'(rte_take), W'(exp_take(k, RTE_LEN)));
      end else begin
        if (state !== 2'd1 || imm_take !== exp_take(k, IMM_LEN) ||
            sel_take !== exp_take(k, SEL_LEN) || rte_take !== exp_take(k, RTE_LEN)) begin
          checks++; errors++;
          $display("FAIL R3 cycle %0d state=%0d takes=%b%b%b expected=1 %b%b%b", k, state,
                   imm_take, sel_take, rte_take,
                   exp_take(k, IMM_LEN), exp_take(k, SEL_LEN), exp_take(k, RTE_LEN));
        end
      end
      if (k == MAX_LEN - 1) chk_cfg("R6 no partial commit");
      tick();
      start_exec = 1'b0; exec_end = 1'b0; start_cfg = 1'b0;
    end
    exp_imm = n_imm; exp_sel = n_sel; exp_rte = n_rte;
    chk_state("R5 enter waiting", 2'd2, 1'b0, 1'b1, 1'b0);
    chk_cfg("R4 R7 committed");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    exp_imm = '0; exp_sel = '0; exp_rte = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk_state("R1 reset", 2'd0, 1'b0, 1'b0, 1'b0);
    chk_cfg("R1 reset");

    // R9: start_exec and exec_end ignored in idle
    start_exec = 1'b1; exec_end = 1'b1;
    tick();
    start_exec = 1'b0; exec_end = 1'b0;
    chk_state("R9 idle ignores exec", 2'd0, 1'b0, 1'b0, 1'b0);

    // R2 R3 R4 R5: all-ones load with a start_exec poke mid-load (R9)
    do_load(1, 1, 3);

    // R9 R10: waiting ignores exec_end and start_cfg
    exec_end = 1'b1; start_cfg = 1'b1;
    tick();
    exec_end = 1'b0; start_cfg = 1'b0;
    chk_state("R9 R10 waiting ignores", 2'd2, 1'b0, 1'b1, 1'b0);
    chk_cfg("R10 cfg unchanged");

    // R8: start execution
    start_exec = 1'b1;
    tick();
    start_exec = 1'b0;
    chk_state("R8 running", 2'd3, 1'b0, 1'b0, 1'b1);

    // R10: start_cfg ignored while running, R9 start_exec too
    start_cfg = 1'b1; start_exec = 1'b1;
    tick();
    start_cfg = 1'b0; start_exec = 1'b0;
    chk_state("R10 running ignores", 2'd3, 1'b0, 1'b0, 1'b1);

    exec_end = 1'b1;
    tick();
    exec_end = 1'b0;
    chk_state("R8 back to idle", 2'd0, 1'b0, 1'b0, 1'b0);
    chk_cfg("R11 held in idle");

    // alternating pattern with exec_end poke, then random with start_cfg poke
    do_load(2, 2, 40);
    start_exec = 1'b1; tick(); start_exec = 1'b0;
    exec_end = 1'b1; tick(); exec_end = 1'b0;
    chk_cfg("R11 held after run");

    do_load(0, 3, SEL_LEN + 2);
    for (int it = 0; it < 3; it++) begin
      start_exec = 1'b1; tick(); start_exec = 1'b0;
      repeat (1 + ($urandom % 5)) tick();
      chk_state("R8 still running", 2'd3, 1'b0, 1'b0, 1'b1);
      exec_end = 1'b1; tick(); exec_end = 1'b0;
      chk_cfg("R11 held");
      do_load(0, int'($urandom % 4), int'($urandom % MAX_LEN));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule